// File: doc/BRIEF.md
# Transmit-Only TCP Sender Control Engine

This block is the decision core of a hardware TCP endpoint whose payload only ever travels outward. It actively opens a single connection to a fixed peer, keeps it open for as long as no fault occurs, and decides cycle by cycle whether to emit a handshake segment, a new data segment, a retransmission or a reset. Framing, checksums, payload storage and the receive data path sit outside. The block sees parsed fields of each received segment (control flags, peer sequence number, acknowledgement number, advertised window), a data-available level, a timer tick and an error strobe. It produces at most one segment request per cycle, described by sequence number, acknowledgement number, length and flags, plus a connection status code.

The connection machine has three states only: closed, connecting and established. Any fault returns it straight to closed and emits a reset segment. Data is sent in fixed segments of `MSS` bytes, kept inside both the peer window and an internal send limit. The send limit is halved on every retransmission timeout and grows back one segment per advancing acknowledgement. The timeout itself starts at a programmable tick count and doubles on each consecutive expiry up to a cap. A third duplicate acknowledgement resends the oldest outstanding segment early. All sequence arithmetic is modulo 2^32, so the behaviour seen on the wire stays that of a standard TCP sender.

Top module: `seg_tx_ctrl`

## Requirements
- R1: After reset, `connState` is 0 (closed) and `txValid` is low. The status codes are 0 closed, 1 connecting, 2 established.
- R2: `openReq` while closed emits one segment with `txFlags` = 3'b001 (bit 0 SYN, bit 1 ACK, bit 2 RST), `txSeq` = `isn` and length 0, and `connState` becomes 1.
- R3: While connecting, a received segment with both SYN and ACK whose acknowledgement equals `isn`+1 moves the state to 2 and emits one pure ACK (flags 3'b010, length 0, `txSeq` = `isn`+1, `txAckNum` = peer sequence + 1).
- R4: `errStrobe`, a received RST, a wrong acknowledgement while connecting, or an acknowledgement beyond the next send sequence (modulo 2^32) while established emits one segment with flags 3'b100 and `txSeq` = next send sequence, and the state returns to 0.
- R5: While established and `dataReady` is high, segments of `MSS` bytes with flags 3'b010, consecutive sequence numbers starting at `isn`+1 and `txAckNum` = peer sequence + 1 are emitted at most one per cycle, and only while outstanding bytes + `MSS` does not exceed the smaller of the peer window and the send limit.
- R6: An acknowledgement that advances the oldest unacknowledged pointer frees window space, so further segments may be sent.
- R7: When the tick count since the last restart reaches the current timeout with data outstanding, the segment at the oldest unacknowledged sequence is resent with length min(`MSS`, outstanding bytes).
- R8: Each consecutive timeout doubles the timeout up to `RTO_MAX` ticks. An advancing acknowledgement restores it to `rtoBase`.
- R9: The send limit starts at `MAX_LIMIT`, halves on every timeout (never below `MSS`) and grows by `MSS` on every advancing acknowledgement (never above `MAX_LIMIT`).
- R10: The third acknowledgement equal to the oldest unacknowledged sequence with data outstanding triggers exactly one resend of that segment. Later duplicates do not trigger it again.
- R11: Sequence, acknowledgement and window arithmetic stays correct across the 2^32 wrap.
- R12: While connecting, a timeout resends the SYN with the same sequence number.
- R13: While closed, received segments and `errStrobe` produce no segment and leave the state closed: the engine never accepts an incoming open.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| openReq | input | 1 | Request to open the connection |
| isn | input | 32 | Initial send sequence number |
| rtoBase | input | RTO_W | Base retransmission timeout in ticks |
| dataReady | input | 1 | At least one segment of payload is available |
| rxValid | input | 1 | Parsed received segment present this cycle |
| rxSyn | input | 1 | Received SYN flag |
| rxAck | input | 1 | Received ACK flag |
| rxRst | input | 1 | Received RST flag |
| rxSeq | input | 32 | Received sequence number |
| rxAckNum | input | 32 | Received acknowledgement number |
| rxWin | input | WIN_W | Received advertised window |
| tick | input | 1 | Timer tick strobe |
| errStrobe | input | 1 | External protocol error |
| txValid | output | 1 | Segment request valid |
| txSeq | output | 32 | Segment sequence number |
| txAckNum | output | 32 | Segment acknowledgement number |
| txLen | output | LEN_W | Segment payload length |
| txFlags | output | 3 | bit0 SYN, bit1 ACK, bit2 RST |
| connState | output | 2 | 0 closed, 1 connecting, 2 established |

## Verification
The hardest situation to reach is the timeout cap after repeated back-off. It needs data outstanding, a run of expiries with no acknowledgement between them, and tick counts that land exactly on the doubled thresholds while the halved send limit also takes effect. The stimulus first fills the window and triggers a fast retransmit, then sends an advancing acknowledgement to restart from a known base. It then applies bursts of ticks one short of each expected threshold, followed by the final tick, until the timeout has saturated. After that, an acknowledgement followed by offered data shows through the count of segments that the send limit was halved and then restored.

// File: rtl/seg_tx_pkg.sv
package seg_tx_pkg;
  localparam int SEQ_W = 32;
  localparam int FLAG_W = 3;
  localparam int FLAG_SYN = 0;
  localparam int FLAG_ACK = 1;
  localparam int FLAG_RST = 2;

  typedef enum logic [1:0] {
    ST_CLOSED      = 2'd0,
    ST_CONNECTING  = 2'd1,
    ST_ESTABLISHED = 2'd2
  } connState_e;

  typedef enum logic [2:0] {
    TX_NONE, TX_SYN, TX_ACK, TX_DATA, TX_RESEND, TX_RST
  } txKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    loadIsn;
    logic    establish;
    logic    ackRx;
    logic    sendNew;
    logic    restartTimer;
    logic    backOff;
    logic    abort;
    txKind_e txKind;
  } dpCtrl_t;

  // conditions from datapath to control
  typedef struct packed {
    logic ackIsNxt;
    logic ackAdvances;
    logic ackInvalid;
    logic dupThird;
    logic canSend;
    logic timeoutDue;
  } dpStat_t;
endpackage

// File: rtl/seg_tx_control.sv
module seg_tx_control
  import seg_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       openReq,
  input  logic       errStrobe,
  input  logic       dataReady,
  input  logic       rxValid,
  input  logic       rxSyn,
  input  logic       rxAck,
  input  logic       rxRst,
  input  dpStat_t    stat,
  output dpCtrl_t    ctl,
  output connState_e state
);
  connState_e nextState;
  logic abortEv;
  logic ackSeen;

  always_comb begin
    ctl = '0;
    ctl.txKind = TX_NONE;
    nextState = state;
    abortEv = errStrobe || (rxValid && rxRst);
    ackSeen = rxValid && rxAck;
    unique case (state)
      ST_CLOSED: begin
        if (openReq) begin
          ctl.loadIsn = 1'b1;
          ctl.txKind = TX_SYN;
          nextState = ST_CONNECTING;
        end
      end
      ST_CONNECTING: begin
        if (abortEv || (ackSeen && !stat.ackIsNxt)) begin
          ctl.abort = 1'b1;
          ctl.txKind = TX_RST;
          nextState = ST_CLOSED;
        end else if (ackSeen && rxSyn) begin
          ctl.establish = 1'b1;
          ctl.txKind = TX_ACK;
          nextState = ST_ESTABLISHED;
        end else if (stat.timeoutDue) begin
          ctl.backOff = 1'b1;
          ctl.restartTimer = 1'b1;
          ctl.txKind = TX_SYN;
        end
      end
      ST_ESTABLISHED: begin
        if (abortEv || (ackSeen && stat.ackInvalid)) begin
          ctl.abort = 1'b1;
          ctl.txKind = TX_RST;
          nextState = ST_CLOSED;
        end else begin
          ctl.ackRx = ackSeen;
          if (ackSeen && stat.dupThird) begin
            ctl.restartTimer = 1'b1;
            ctl.txKind = TX_RESEND;
          end else if (stat.timeoutDue && !(ackSeen && stat.ackAdvances)) begin
            ctl.backOff = 1'b1;
            ctl.restartTimer = 1'b1;
            ctl.txKind = TX_RESEND;
          end else if (dataReady && stat.canSend) begin
            ctl.sendNew = 1'b1;
            ctl.txKind = TX_DATA;
          end
        end
      end
      default: nextState = ST_CLOSED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_CLOSED;
    else       state <= nextState;
  end
endmodule

// File: rtl/seg_tx_datapath.sv
module seg_tx_datapath
  import seg_tx_pkg::*;
#(
  parameter int MSS       = 1000,
  parameter int MAX_LIMIT = 8000,
  parameter int WIN_W     = 16,
  parameter int LEN_W     = 16,
  parameter int RTO_W     = 16,
  parameter int RTO_MAX   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctl,
  input  logic [SEQ_W-1:0]  isn,
  input  logic [RTO_W-1:0]  rtoBase,
  input  logic              tick,
  input  logic [SEQ_W-1:0]  rxSeq,
  input  logic [SEQ_W-1:0]  rxAckNum,
  input  logic [WIN_W-1:0]  rxWin,
  output dpStat_t           stat,
  output logic              txValid,
  output logic [SEQ_W-1:0]  txSeq,
  output logic [SEQ_W-1:0]  txAckNum,
  output logic [LEN_W-1:0]  txLen,
  output logic [FLAG_W-1:0] txFlags
);
  localparam logic [SEQ_W-1:0] MSS_S     = SEQ_W'(MSS);
  localparam logic [SEQ_W-1:0] LIMIT_MAX = SEQ_W'(MAX_LIMIT);
  localparam logic [LEN_W-1:0] MSS_L     = LEN_W'(MSS);
  localparam logic [RTO_W-1:0] RTO_CAP   = RTO_W'(RTO_MAX);
  localparam logic [RTO_W:0]   RTO_CAP_X = (RTO_W+1)'(RTO_MAX);

  logic [SEQ_W-1:0] sndUna, sndNxt, rcvNxt, isnReg, sendLimit;
  logic [SEQ_W-1:0] inflight, ackDelta, effWin, grownLimit, halvedLimit, grownSum;
  logic [SEQ_W:0]   needed;
  logic [WIN_W-1:0] peerWin;
  logic [RTO_W-1:0] rtoCur, timerCnt, rtoNext;
  logic [RTO_W:0]   rtoDbl;
  logic [LEN_W-1:0] resendLen;
  logic [1:0]       dupCnt;
  logic             armed, ackIsDup;

  always_comb begin
    inflight = sndNxt - sndUna;
    ackDelta = rxAckNum - sndUna;
    effWin = (SEQ_W'(peerWin) < sendLimit) ? SEQ_W'(peerWin) : sendLimit;
    needed = {1'b0, inflight} + {1'b0, MSS_S};
    ackIsDup = (ackDelta == '0) && (inflight != '0);
    armed = inflight != '0;
    stat.canSend = needed <= {1'b0, effWin};
    stat.ackIsNxt = rxAckNum == sndNxt;
    stat.ackAdvances = (ackDelta != '0) && (ackDelta <= inflight);
    stat.ackInvalid = ackDelta > inflight;
    stat.dupThird = ackIsDup && (dupCnt == 2'd2);
    stat.timeoutDue = armed && (timerCnt >= rtoCur);
    rtoDbl = {rtoCur, 1'b0};
    rtoNext = (rtoDbl > RTO_CAP_X) ? RTO_CAP : rtoDbl[RTO_W-1:0];
    grownSum = sendLimit + MSS_S;
    grownLimit = (grownSum > LIMIT_MAX) ? LIMIT_MAX : grownSum;
    halvedLimit = ((sendLimit >> 1) < MSS_S) ? MSS_S : (sendLimit >> 1);
    resendLen = (inflight < MSS_S) ? inflight[LEN_W-1:0] : MSS_L;
  end

  // connection bookkeeping: later statements take precedence
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sndUna <= '0;
      sndNxt <= '0;
      rcvNxt <= '0;
      isnReg <= '0;
      peerWin <= '0;
      sendLimit <= LIMIT_MAX;
      rtoCur <= RTO_CAP;
      timerCnt <= '0;
      dupCnt <= '0;
    end else begin
      if (armed && tick && (timerCnt != '1)) timerCnt <= timerCnt + 1'b1;
      if (ctl.sendNew) sndNxt <= sndNxt + MSS_S;
      if (ctl.ackRx) begin
        peerWin <= rxWin;
        if (stat.ackAdvances) begin
          sndUna <= rxAckNum;
          dupCnt <= '0;
          timerCnt <= '0;
          rtoCur <= rtoBase;
          sendLimit <= grownLimit;
        end else if (ackIsDup && (dupCnt != 2'd3)) begin
          dupCnt <= dupCnt + 1'b1;
        end
      end
      if (ctl.restartTimer) timerCnt <= '0;
      if (ctl.backOff) begin
        rtoCur <= rtoNext;
        sendLimit <= halvedLimit;
        dupCnt <= '0;
      end
      if (ctl.establish) begin
        sndUna <= rxAckNum;
        rcvNxt <= rxSeq + 1'b1;
        peerWin <= rxWin;
        timerCnt <= '0;
        rtoCur <= rtoBase;
      end
      if (ctl.loadIsn) begin
        isnReg <= isn;
        sndUna <= isn;
        sndNxt <= isn + 1'b1;
        timerCnt <= '0;
        dupCnt <= '0;
        rtoCur <= rtoBase;
        sendLimit <= LIMIT_MAX;
      end
      if (ctl.abort) begin
        sndUna <= sndNxt;
        timerCnt <= '0;
        dupCnt <= '0;
      end
    end
  end

  // registered segment request
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txValid <= 1'b0;
      txSeq <= '0;
      txAckNum <= '0;
      txLen <= '0;
      txFlags <= '0;
    end else begin
      txValid <= ctl.txKind != TX_NONE;
      txLen <= '0;
      txFlags <= '0;
      txAckNum <= rcvNxt;
      txSeq <= sndNxt;
      unique case (ctl.txKind)
        TX_SYN: begin
          txSeq <= ctl.loadIsn ? isn : isnReg;
          txAckNum <= '0;
          txFlags[FLAG_SYN] <= 1'b1;
        end
        TX_ACK: begin
          txSeq <= rxAckNum;
          txAckNum <= rxSeq + 1'b1;
          txFlags[FLAG_ACK] <= 1'b1;
        end
        TX_DATA: begin
          txLen <= MSS_L;
          txFlags[FLAG_ACK] <= 1'b1;
        end
        TX_RESEND: begin
          txSeq <= sndUna;
          txLen <= resendLen;
          txFlags[FLAG_ACK] <= 1'b1;
        end
        TX_RST: txFlags[FLAG_RST] <= 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/seg_tx_ctrl.sv
module seg_tx_ctrl
  import seg_tx_pkg::*;
#(
  parameter int MSS       = 1000,
  parameter int MAX_LIMIT = 8000,
  parameter int WIN_W     = 16,
  parameter int LEN_W     = 16,
  parameter int RTO_W     = 16,
  parameter int RTO_MAX   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              openReq,
  input  logic [31:0]       isn,
  input  logic [RTO_W-1:0]  rtoBase,
  input  logic              dataReady,
  input  logic              rxValid,
  input  logic              rxSyn,
  input  logic              rxAck,
  input  logic              rxRst,
  input  logic [31:0]       rxSeq,
  input  logic [31:0]       rxAckNum,
  input  logic [WIN_W-1:0]  rxWin,
  input  logic              tick,
  input  logic              errStrobe,
  output logic              txValid,
  output logic [31:0]       txSeq,
  output logic [31:0]       txAckNum,
  output logic [LEN_W-1:0]  txLen,
  output logic [2:0]        txFlags,
  output logic [1:0]        connState
);
  dpCtrl_t    ctl;
  dpStat_t    stat;
  connState_e state;

  seg_tx_control i_control (
    .clk(clk), .rstN(rstN), .openReq(openReq), .errStrobe(errStrobe),
    .dataReady(dataReady), .rxValid(rxValid), .rxSyn(rxSyn), .rxAck(rxAck),
    .rxRst(rxRst), .stat(stat), .ctl(ctl), .state(state)
  );

  seg_tx_datapath #(
    .MSS(MSS), .MAX_LIMIT(MAX_LIMIT), .WIN_W(WIN_W), .LEN_W(LEN_W),
    .RTO_W(RTO_W), .RTO_MAX(RTO_MAX)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .isn(isn), .rtoBase(rtoBase),
    .tick(tick), .rxSeq(rxSeq), .rxAckNum(rxAckNum), .rxWin(rxWin),
    .stat(stat), .txValid(txValid), .txSeq(txSeq), .txAckNum(txAckNum),
    .txLen(txLen), .txFlags(txFlags)
  );

  assign connState = state;
endmodule

// File: rtl/seg_tx_chk.sv
module seg_tx_chk #(
  parameter int LEN_W = 16,
  parameter int MSS   = 1000
) (
  input logic             clk,
  input logic             rstN,
  input logic             txValid,
  input logic [LEN_W-1:0] txLen,
  input logic [2:0]       txFlags,
  input logic [1:0]       connState
);
  localparam logic [LEN_W-1:0] MSS_L = LEN_W'(MSS);

  // R1: only the three status codes ever appear
  a_r1_state_legal: assert property (@(posedge clk) disable iff (!rstN)
    connState != 2'd3);

  // R2, R12: a SYN leaves only while connecting
  a_r2_syn_connecting: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txFlags[0]) |-> (connState == 2'd1));

  // R4: a reset segment always comes with the return to closed
  a_r4_rst_closes: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txFlags[2]) |-> (connState == 2'd0));

  // R5: payload only when established, ACK-only flags, never above MSS
  a_r5_payload_shape: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && (txLen != '0)) |-> (connState == 2'd2 && txFlags == 3'b010 && txLen <= MSS_L));

  // R3: established is entered only from connecting
  a_r3_enter_from_connecting: assert property (@(posedge clk) disable iff (!rstN)
    $rose(connState == 2'd2) |-> ($past(connState) == 2'd1));

  // R13: staying closed means staying silent
  a_r13_closed_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (connState == 2'd0 && $past(connState) == 2'd0) |-> !txValid);
endmodule

bind seg_tx_ctrl seg_tx_chk #(.LEN_W(LEN_W), .MSS(MSS)) i_chk (
  .clk(clk), .rstN(rstN), .txValid(txValid), .txLen(txLen),
  .txFlags(txFlags), .connState(connState)
);

// File: tb/test_seg_tx_ctrl.sv
module test_seg_tx_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int MSS = 1000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic openReq = 0, dataReady = 0, rxValid = 0, rxSyn = 0, rxAck = 0, rxRst = 0;
  logic tick = 0, errStrobe = 0;
  logic [31:0] isn = '0, rxSeq = '0, rxAckNum = '0;
  logic [15:0] rtoBase = 16'd4, rxWin = '0;
  logic txValid;
  logic [31:0] txSeq, txAckNum;
  logic [15:0] txLen;
  logic [2:0] txFlags;
  logic [1:0] connState;

  int nChecks = 0, nErrors = 0, nTx = 0;
  logic [31:0] capSeq[64], capAck[64];
  logic [15:0] capLen[64];
  logic [2:0]  capFlg[64];

  seg_tx_ctrl i_seg_tx_ctrl (
    .clk(clk), .rstN(rstN), .openReq(openReq), .isn(isn), .rtoBase(rtoBase),
    .dataReady(dataReady), .rxValid(rxValid), .rxSyn(rxSyn), .rxAck(rxAck),
    .rxRst(rxRst), .rxSeq(rxSeq), .rxAckNum(rxAckNum), .rxWin(rxWin),
    .tick(tick), .errStrobe(errStrobe), .txValid(txValid), .txSeq(txSeq),
    .txAckNum(txAckNum), .txLen(txLen), .txFlags(txFlags), .connState(connState)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (txValid && nTx < 64) begin
      capSeq[nTx] = txSeq;
      capAck[nTx] = txAckNum;
      capLen[nTx] = txLen;
      capFlg[nTx] = txFlags;
      nTx = nTx + 1;
    end
  end

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic chkCount(input int exp, input string tag);
    chk(nTx == exp, tag, "segment count", nTx, exp);
  endtask

  task automatic chkTx(input int idx, input logic [31:0] seq, input logic [31:0] ack,
                       input logic [15:0] len, input logic [2:0] flg, input string tag);
    if (idx >= nTx) begin
      chk(1'b0, tag, "segment missing, count", nTx, idx + 1);
    end else begin
      chk(capSeq[idx] == seq, tag, "seq", capSeq[idx], seq);
      chk(capAck[idx] == ack, tag, "ack", capAck[idx], ack);
      chk(capLen[idx] == len, tag, "len", {16'd0, capLen[idx]}, {16'd0, len});
      chk(capFlg[idx] == flg, tag, "flags", {29'd0, capFlg[idx]}, {29'd0, flg});
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    step(3);
    rstN = 1'b1;
    step(1);
  endtask

  task automatic pulseRx(input bit s, input bit a, input bit r, input logic [31:0] sq,
                         input logic [31:0] an, input logic [15:0] w);
    rxValid = 1; rxSyn = s; rxAck = a; rxRst = r; rxSeq = sq; rxAckNum = an; rxWin = w;
    step(1);
    rxValid = 0; rxSyn = 0; rxAck = 0; rxRst = 0;
    step(2);
  endtask

  task automatic ticks(input int n);
    tick = 1;
    step(n);
    tick = 0;
    step(3);
  endtask

  task automatic offerData(input int cycles);
    dataReady = 1;
    step(cycles);
    dataReady = 0;
    step(2);
  endtask

  task automatic openReqPulse(input logic [31:0] v);
    isn = v;
    openReq = 1;
    step(1);
    openReq = 0;
    step(2);
  endtask

  task automatic openConn(input logic [31:0] v, input logic [31:0] peer,
                          input logic [15:0] w, input string tag);
    int base;
    base = nTx;
    openReqPulse(v);
    chkTx(base, v, 32'd0, 16'd0, 3'b001, tag);
    pulseRx(1, 1, 0, peer, v + 1, w);
    chkTx(base + 1, v + 1, peer + 1, 16'd0, 3'b010, tag);
    chk(connState == 2'd2, tag, "state established", connState, 2);
  endtask

  task automatic testReset();
    doReset();
    chk(connState == 2'd0, "R1", "reset state", connState, 0);
    chk(txValid == 1'b0, "R1", "reset txValid", txValid, 0);
    chkCount(0, "R1");
  endtask

  task automatic testClosedIgnores();
    pulseRx(1, 0, 0, 32'd10, 32'd0, 16'd100);
    pulseRx(1, 1, 0, 32'd10, 32'd1, 16'd100);
    errStrobe = 1; step(1); errStrobe = 0; step(2);
    chkCount(0, "R13");
    chk(connState == 2'd0, "R13", "still closed", connState, 0);
  endtask

  // handshake with one SYN timeout; leaves send limit 4000, peer window 3000
  task automatic testHandshake();
    openReqPulse(32'd1000);
    chkTx(0, 32'd1000, 32'd0, 16'd0, 3'b001, "R2");
    chk(connState == 2'd1, "R2", "state connecting", connState, 1);
    ticks(3);
    chkCount(1, "R12");
    ticks(1);
    chkTx(1, 32'd1000, 32'd0, 16'd0, 3'b001, "R12");
    pulseRx(1, 1, 0, 32'd5000, 32'd1001, 16'd3000);
    chkTx(2, 32'd1001, 32'd5001, 16'd0, 3'b010, "R3");
    chk(connState == 2'd2, "R3", "state established", connState, 2);
  endtask

  task automatic testWindow();
    offerData(10);
    chkCount(6, "R5");
    for (int k = 0; k < 3; k++)
      chkTx(3 + k, 32'd1001 + k * MSS, 32'd5001, 16'd1000, 3'b010, "R5");
    pulseRx(0, 1, 0, 32'd5001, 32'd2001, 16'd3000);
    chkCount(6, "R6");
    offerData(10);
    chkCount(7, "R6");
    chkTx(6, 32'd4001, 32'd5001, 16'd1000, 3'b010, "R6");
  endtask

  task automatic testFastRetx();
    pulseRx(0, 1, 0, 32'd5001, 32'd2001, 16'd3000);
    pulseRx(0, 1, 0, 32'd5001, 32'd2001, 16'd3000);
    chkCount(7, "R10");
    pulseRx(0, 1, 0, 32'd5001, 32'd2001, 16'd3000);
    chkTx(7, 32'd2001, 32'd5001, 16'd1000, 3'b010, "R10");
    pulseRx(0, 1, 0, 32'd5001, 32'd2001, 16'd3000);
    chkCount(8, "R10");
  endtask

  task automatic testBackoff();
    int b;
    pulseRx(0, 1, 0, 32'd5001, 32'd3001, 16'd3000);
    b = nTx;
    ticks(4);
    chkTx(b, 32'd3001, 32'd5001, 16'd1000, 3'b010, "R7");
    ticks(7);
    chkCount(b + 1, "R8");
    ticks(1);
    chkTx(b + 1, 32'd3001, 32'd5001, 16'd1000, 3'b010, "R8");
    ticks(15);
    chkCount(b + 2, "R8");
    ticks(1);
    chkCount(b + 3, "R8");
    ticks(31);
    chkCount(b + 3, "R8");
    ticks(1);
    chkCount(b + 4, "R8");
    ticks(31);
    chkCount(b + 4, "R8");
    ticks(1);
    chkTx(b + 4, 32'd3001, 32'd5001, 16'd1000, 3'b010, "R8");
    pulseRx(0, 1, 0, 32'd5001, 32'd5001, 16'd8000);
    offerData(10);
    chkCount(b + 7, "R9");
    chkTx(b + 5, 32'd5001, 32'd5001, 16'd1000, 3'b010, "R9");
    chkTx(b + 6, 32'd6001, 32'd5001, 16'd1000, 3'b010, "R9");
    ticks(4);
    chkTx(b + 7, 32'd5001, 32'd5001, 16'd1000, 3'b010, "R8");
    pulseRx(0, 1, 0, 32'd5001, 32'd6001, 16'd8000);
    offerData(10);
    chkCount(b + 9, "R9");
    chkTx(b + 8, 32'd7001, 32'd5001, 16'd1000, 3'b010, "R9");
    pulseRx(0, 1, 0, 32'd5001, 32'd13001, 16'd8000);
    chkTx(b + 9, 32'd8001, 32'd5001, 16'd0, 3'b100, "R4");
    chk(connState == 2'd0, "R4", "closed after bad ack", connState, 0);
  endtask

  task automatic testWrap();
    logic [31:0] w0;
    int b;
    w0 = 32'hFFFF_FC00;
    doReset();
    b = nTx;
    openConn(w0, 32'hFFFF_FFFF, 16'd4000, "R11");
    offerData(10);
    chkCount(b + 6, "R11");
    for (int k = 0; k < 4; k++)
      chkTx(b + 2 + k, w0 + 1 + k * MSS, 32'd0, 16'd1000, 3'b010, "R11");
    pulseRx(0, 1, 0, 32'd0, w0 + 1 + 2000, 16'd4000);
    chk(connState == 2'd2, "R11", "ack across wrap accepted", connState, 2);
    offerData(10);
    chkCount(b + 8, "R11");
    chkTx(b + 6, w0 + 1 + 4000, 32'd0, 16'd1000, 3'b010, "R11");
    errStrobe = 1; step(1); errStrobe = 0; step(2);
    chkTx(b + 8, w0 + 1 + 6000, 32'd0, 16'd0, 3'b100, "R4");
    chk(connState == 2'd0, "R4", "closed after error strobe", connState, 0);
  endtask

  task automatic testConnectAbort();
    int b;
    b = nTx;
    openReqPulse(32'd500);
    pulseRx(1, 1, 0, 32'd77, 32'd999, 16'd100);
    chk(nTx == b + 2, "R4", "count after wrong syn-ack", nTx, b + 2);
    chk(capSeq[b + 1] == 32'd501, "R4", "rst seq", capSeq[b + 1], 501);
    chk(capFlg[b + 1] == 3'b100, "R4", "rst flags", {29'd0, capFlg[b + 1]}, 4);
    chk(connState == 2'd0, "R4", "closed after wrong ack", connState, 0);
    b = nTx;
    openConn(32'd700, 32'd90, 16'd2000, "R3");
    pulseRx(0, 0, 1, 32'd91, 32'd0, 16'd0);
    chkTx(b + 2, 32'd701, 32'd91, 16'd0, 3'b100, "R4");
    chk(connState == 2'd0, "R4", "closed after peer reset", connState, 0);
  endtask

  initial begin
    testReset();
    testClosedIgnores();
    testHandshake();
    testWindow();
    testFastRetx();
    testBackoff();
    testWrap();
    testConnectAbort();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nErrors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule